// File: doc/BRIEF.md
# Retentive Edge-Triggered Up/Down Event Counter

This block is the counting element of a programmable controller's logic engine. It watches two level inputs, one for counting up and one for counting down. Each false-to-true transition of a count input moves a signed accumulator by one step. A level that stays true adds no further counts. The accumulator keeps its value for as long as needed, whatever the inputs do, until a separate clear command returns it to zero.

The accumulator is compared, as a signed number, with a preset supplied on a port. The result drives a done flag that is true whenever the count has reached or passed the preset, and a negative preset works as expected. When a count steps past either end of the signed range, the value wraps around and a sticky flag records it. Up and down edges that arrive in the same cycle cancel each other.

Top module: `plc_event_counter`

## Requirements
- R1: Each cycle in which `up_i` is 1 after being sampled 0 on the previous clock (a rise) increments `acc_o` by exactly one at that clock edge. A held 1 adds no further counts.
- R2: Each rise of `dn_i` decrements `acc_o` by exactly one at that clock edge. A held 1 subtracts no further counts.
- R3: `done_o` is 1 exactly when `acc_o` is greater than or equal to `preset_i`, with both read as two's-complement signed values. The comparison is combinational, so it follows a preset change in the same cycle.
- R4: With no rise on either count input and `clr_i` low, `acc_o` keeps its value indefinitely.
- R5: A rise of `up_i` while `acc_o` is +32767 (0x7FFF) wraps `acc_o` to -32768 (0x8000) and sets `ovf_o`. `ovf_o` then stays set until a clear or reset.
- R6: A rise of `dn_i` while `acc_o` is -32768 (0x8000) wraps `acc_o` to +32767 (0x7FFF) and sets `unf_o`. `unf_o` then stays set until a clear or reset.
- R7: Rises of `up_i` and `dn_i` at the same clock edge leave `acc_o` unchanged.
- R8: `clr_i` high at a clock edge sets `acc_o` to 0 and clears `ovf_o` and `unf_o` at that edge. It takes priority over any rise in the same cycle. Input history is still tracked during a clear.
- R9: `up_en_o` equals the current level of `up_i`, and `dn_en_o` equals the current level of `dn_i`.
- R10: Asynchronous reset (`rst_ni` low) sets `acc_o` to 0, clears both sticky flags, and sets the input history to 0. A count input already high at the first clock after reset therefore counts once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | Count-up level input |
| dn_i | input | 1 | Count-down level input |
| clr_i | input | 1 | Synchronous clear command for the accumulator and sticky flags |
| preset_i | input | 16 | Signed preset for the done comparison |
| acc_o | output | 16 | Signed accumulator |
| up_en_o | output | 1 | Count-up input is currently true |
| dn_en_o | output | 1 | Count-down input is currently true |
| done_o | output | 1 | Accumulator is greater than or equal to the preset (signed) |
| ovf_o | output | 1 | Sticky flag: an up-count wrapped past the top of the range |
| unf_o | output | 1 | Sticky flag: a down-count wrapped past the bottom of the range |

## Verification
The counting function is driven in several patterns, each of which separates edge counting from level counting:
- Isolated pulses on one input.
- Levels held true across several cycles, which would add extra counts in a level-sensitive design.
- Rises on both inputs together, which would expose a priority design where a cancellation is expected.
- A clear raised together with a rise, which would expose a counting path that bypasses the clear.

Signed handling is tried in two ways. Negative presets are paired with positive and negative counts. Long pulse trains walk the accumulator to both ends of its range, which separates a wrapping, flag-setting design from one that saturates or forgets the flag. A count input held high through reset checks that the input history restarts at zero.

// File: rtl/plc_cnt_pkg.sv
package plc_cnt_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10
  } step_e;

  function automatic step_e step_decode(input logic rise_up, input logic rise_dn);
    if (rise_up && !rise_dn)      return STEP_INC;
    else if (rise_dn && !rise_up) return STEP_DEC;
    else                          return STEP_NONE;
  endfunction
endpackage

// File: rtl/plc_cnt_edge.sv
module plc_cnt_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[g] <= 1'b0;
      else         lvl_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
  end
endmodule

// File: rtl/plc_cnt_acc.sv
module plc_cnt_acc
  import plc_cnt_pkg::*;
#(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             rise_up_i,
  input  logic             rise_dn_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam logic [ACC_W-1:0] AccMax = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] AccMin = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] One    = {{(ACC_W-1){1'b0}}, 1'b1};

  step_e            step;
  logic [ACC_W-1:0] acc_q;
  logic             ovf_q, unf_q;

  assign step = step_decode(rise_up_i, rise_dn_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (clr_i) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      unique case (step)
        STEP_INC: begin
          acc_q <= acc_q + One;  // wraps max -> min
          if (acc_q == AccMax) ovf_q <= 1'b1;
        end
        STEP_DEC: begin
          acc_q <= acc_q - One;  // wraps min -> max
          if (acc_q == AccMin) unf_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;
endmodule

// File: rtl/plc_cnt_cmp.sv
module plc_cnt_cmp #(
  parameter int unsigned ACC_W = 16
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] preset_i,
  output logic             ge_o
);
  assign ge_o = $signed(acc_i) >= $signed(preset_i);
endmodule

// File: rtl/plc_event_counter.sv
module plc_event_counter #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] preset_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             up_en_o,
  output logic             dn_en_o,
  output logic             done_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam int unsigned NumIn = 2;

  logic [NumIn-1:0] rise;

  plc_cnt_edge #(.N(NumIn)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({dn_i, up_i}),
    .rise_o (rise)
  );

  plc_cnt_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .rise_up_i (rise[0]),
    .rise_dn_i (rise[1]),
    .acc_o     (acc_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o)
  );

  plc_cnt_cmp #(.ACC_W(ACC_W)) u_cmp (
    .acc_i    (acc_o),
    .preset_i (preset_i),
    .ge_o     (done_o)
  );

  assign up_en_o = up_i;
  assign dn_en_o = dn_i;
endmodule

// File: rtl/plc_event_counter_chk.sv
module plc_event_counter_chk #(
  parameter int unsigned ACC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             up_i,
  input logic             dn_i,
  input logic             clr_i,
  input logic [ACC_W-1:0] preset_i,
  input logic [ACC_W-1:0] acc_o,
  input logic             up_en_o,
  input logic             dn_en_o,
  input logic             done_o,
  input logic             ovf_o,
  input logic             unf_o
);
  localparam logic [ACC_W-1:0] AccMax = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] AccMin = {1'b1, {(ACC_W-1){1'b0}}};

  logic up_q, dn_q, up_r, dn_r;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_i;
      dn_q <= dn_i;
    end
  end
  assign up_r = up_i && !up_q;
  assign dn_r = dn_i && !dn_q;

  p_count_up_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_r && !dn_r && !clr_i && acc_o != AccMax) |=> acc_o == $past(acc_o) + 1'b1);
  p_count_dn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_r && !up_r && !clr_i && acc_o != AccMin) |=> acc_o == $past(acc_o) - 1'b1);
  p_done_cmp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == ($signed(acc_o) >= $signed(preset_i)));
  p_retain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_r && !dn_r && !clr_i) |=> $stable(acc_o));
  p_wrap_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_r && !dn_r && !clr_i && acc_o == AccMax) |=> (acc_o == AccMin && ovf_o));
  p_ovf_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);
  p_wrap_dn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_r && !up_r && !clr_i && acc_o == AccMin) |=> (acc_o == AccMax && unf_o));
  p_unf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_o && !clr_i) |=> unf_o);
  p_cancel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_r && dn_r && !clr_i) |=> $stable(acc_o));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_o == '0 && !ovf_o && !unf_o));
  p_enable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_en_o == up_i) && (dn_en_o == dn_i));
endmodule

bind plc_event_counter plc_event_counter_chk #(.ACC_W(ACC_W)) u_chk (.*);

// File: tb/plc_event_counter_tb_top.sv
module plc_event_counter_tb_top;
  localparam int unsigned W = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic up_i = 1'b0, dn_i = 1'b0, clr_i = 1'b0;
  logic [W-1:0] preset_i = '0;
  logic [W-1:0] acc_o;
  logic up_en_o, dn_en_o, done_o, ovf_o, unf_o;

  int checks = 0, failures = 0;

  always #5 clk_i = ~clk_i;

  plc_event_counter #(.ACC_W(W)) dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // vector: clr, up, dn, preset[15:0], exp_acc[15:0], exp_done
  localparam int NV = 18;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,16'd3,     16'd1,     1'b0}, // R1 rise
    {1'b0,1'b1,1'b0,16'd3,     16'd1,     1'b0}, // R1 held
    {1'b0,1'b0,1'b0,16'd3,     16'd1,     1'b0}, // R4
    {1'b0,1'b1,1'b0,16'd3,     16'd2,     1'b0}, // R1
    {1'b0,1'b0,1'b0,16'd3,     16'd2,     1'b0},
    {1'b0,1'b1,1'b0,16'd3,     16'd3,     1'b1}, // R3 equal
    {1'b0,1'b0,1'b1,16'd3,     16'd2,     1'b0}, // R2
    {1'b0,1'b0,1'b1,16'd3,     16'd2,     1'b0}, // R2 held
    {1'b0,1'b0,1'b0,16'hFFFB,  16'd2,     1'b1}, // R3 negative preset
    {1'b0,1'b1,1'b1,16'hFFFB,  16'd2,     1'b1}, // R7 cancel
    {1'b0,1'b0,1'b0,16'hFFFB,  16'd2,     1'b1},
    {1'b0,1'b0,1'b1,16'hFFFB,  16'd1,     1'b1}, // R2
    {1'b1,1'b0,1'b0,16'hFFFB,  16'd0,     1'b1}, // R8
    {1'b0,1'b0,1'b1,16'hFFFB,  16'hFFFF,  1'b1}, // R2 negative
    {1'b0,1'b0,1'b0,16'hFFFB,  16'hFFFF,  1'b1}, // R4
    {1'b0,1'b0,1'b1,16'h0000,  16'hFFFE,  1'b0}, // R3 negative acc
    {1'b1,1'b1,1'b0,16'h0000,  16'd0,     1'b1}, // R8 priority over rise
    {1'b0,1'b1,1'b0,16'h0000,  16'd0,     1'b1}  // R8 history kept, held
  };

  task automatic pulse(input logic up, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i); if (up) up_i = 1'b1; else dn_i = 1'b1;
      @(negedge clk_i); up_i = 1'b0; dn_i = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    check("R10 reset acc", 32'(acc_o), 0);
    check("R10 reset ovf/unf", {30'd0, ovf_o, unf_o}, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {clr_i, up_i, dn_i, preset_i} = VEC[i][35:17];
      @(negedge clk_i);
      check($sformatf("R1/R2/R3/R4/R7/R8 vec%0d acc", i), 32'(acc_o), 32'(VEC[i][16:1]));
      check($sformatf("R3 vec%0d done", i), 32'(done_o), 32'(VEC[i][0]));
    end
    clr_i = 1'b0; up_i = 1'b0; dn_i = 1'b0;

    // R9 enable flags follow levels
    @(negedge clk_i); up_i = 1'b1; #1;
    check("R9 up_en high", {30'd0, up_en_o, dn_en_o}, 32'b10);
    up_i = 1'b0; dn_i = 1'b1; #1;
    check("R9 dn_en high", {30'd0, up_en_o, dn_en_o}, 32'b01);
    dn_i = 1'b0;
    @(negedge clk_i); clr_i = 1'b1; @(negedge clk_i); clr_i = 1'b0;

    // R5 overflow
    pulse(1'b1, 32767);
    check("R5 at max", 32'(acc_o), 32'h7FFF);
    check("R5 no ovf yet", 32'(ovf_o), 0);
    pulse(1'b1, 1);
    check("R5 wrap to min", 32'(acc_o), 32'h8000);
    check("R5 ovf set", 32'(ovf_o), 1);
    pulse(1'b0, 1);
    check("R5 ovf sticky", 32'(ovf_o), 1);
    check("R6 wrap back to max", 32'(acc_o), 32'h7FFF);
    check("R6 unf set", 32'(unf_o), 1);
    @(negedge clk_i); clr_i = 1'b1; @(negedge clk_i); clr_i = 1'b0;
    check("R8 clear flags", {30'd0, ovf_o, unf_o}, 0);

    // R6 underflow from zero
    pulse(1'b0, 32768);
    check("R6 at min", 32'(acc_o), 32'h8000);
    check("R6 no unf yet", 32'(unf_o), 0);
    pulse(1'b0, 1);
    check("R6 wrap to max", 32'(acc_o), 32'h7FFF);
    check("R6 unf set", 32'(unf_o), 1);
    check("R6 ovf clear", 32'(ovf_o), 0);

    // R10 reset with up held: history restarts at zero
    @(negedge clk_i); up_i = 1'b1; rst_ni = 1'b0; #1;
    check("R10 async acc", 32'(acc_o), 0);
    check("R10 async flags", {30'd0, ovf_o, unf_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 held input counts once", 32'(acc_o), 1);
    @(negedge clk_i);
    check("R1 held after reset", 32'(acc_o), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule